// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This engine serves one IN endpoint. Software fills a ring of 16-byte descriptors in memory and hands each one over by setting its ownership bit and a checksum. The engine fetches a descriptor and checks it. It then streams the payload the descriptor points to into the endpoint FIFO, one 32-bit word at a time. After that it writes the descriptor back with ownership returned and follows the next-descriptor pointer. A descriptor that software has not handed over stops the walk, and the engine waits there. Software can then re-arm that descriptor and issue a resume.

Descriptor layout, little-endian, as four 32-bit words:

| Word | Bits | Content |
|------|------|---------|
| word 0 | 7:0 | flag byte |
| word 0 | 15:8 | checksum |
| word 0 | 23:16 | extension byte |
| word 1 | all | next-descriptor byte address |
| word 2 | all | buffer byte address |
| word 3 | 15:0 | requested length |
| word 3 | 31:16 | length written back by the engine |

Flag bits: bit 0 means hardware-owned, bit 2 means skip, bit 7 means signal on completion. Extension bit 5 asks for a trailing zero-length packet.

Memory is a single port with a one-cycle registered read. Control is by single-cycle command pulses.

Top module: `tdq_engine`

## Requirements
- R1: After reset `q_active`, `pkt_valid`, `mem_req` and all three event outputs are low.
- R2: A `q_start` pulse while inactive loads `q_start_addr` into `q_cur_ptr` and raises `q_active`. A `q_start` while active changes neither `q_cur_ptr` nor `q_active`.
- R3: A descriptor whose flag bit 0 is clear sends nothing and is not written. The engine parks on it with `q_active` high and `q_cur_ptr` equal to its address.
- R4: The checksum rule is as follows. Sum all 16 bytes mod 256, with byte 1 taken as zero and flag bit 0 taken as zero, then add 1. Byte 1 must equal 0xFF minus that sum. On a mismatch the engine pulses `evt_cs_err` for one cycle, sends nothing and parks on the descriptor.
- R5: A valid descriptor of length L sends ceil(L/4) beats. The beats carry the buffer words in ascending address order, and `pkt_last` is set only on the final data beat.
- R6: On completion the engine writes word 3 bits 31:16 with the length sent, leaves bits 15:0 as they were, and clears flag bit 0 in word 0. `q_cur_ptr` then takes the next-descriptor address from word 1.
- R7: `evt_done` pulses once per completed descriptor whose flag bit 7 is set, and never otherwise.
- R8: When `zlp_en` is high and extension bit 5 is set, one extra beat follows the data, with `pkt_zlp=1`, `pkt_last=1` and zero data. No such beat is sent otherwise.
- R9: A descriptor with flag bit 2 set sends no beats, whatever its length. It is written back with length 0 and the engine moves to the next descriptor.
- R10: A descriptor of length 0 with flag bit 2 clear pulses `evt_len_err`, sends nothing and parks on it.
- R11: A `q_resume` pulse while parked fetches the descriptor at `q_cur_ptr` again and processes it.
- R12: `q_stop` clears `q_active` on the next cycle and drops any pending beat. No further beats or memory accesses follow until a new start.
- R13: A beat held with `pkt_ready` low keeps `pkt_valid`, `pkt_data`, `pkt_last` and `pkt_zlp` stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| q_start | input | 1 | start pulse |
| q_start_addr | input | ADDR_W | byte address of the first descriptor |
| q_stop | input | 1 | stop pulse |
| q_resume | input | 1 | resume pulse |
| zlp_en | input | 1 | allow trailing zero-length packets |
| q_active | output | 1 | queue running or parked |
| q_cur_ptr | output | ADDR_W | address of the descriptor in hand |
| evt_done | output | 1 | completion pulse |
| evt_cs_err | output | 1 | checksum mismatch pulse |
| evt_len_err | output | 1 | zero-length pulse |
| mem_req | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | ADDR_W-2 | word address |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid one cycle after a read |
| pkt_valid | output | 1 | beat valid |
| pkt_ready | input | 1 | FIFO accepts beat |
| pkt_data | output | 32 | beat payload |
| pkt_last | output | 1 | final beat of descriptor |
| pkt_zlp | output | 1 | beat is a zero-length packet |

## Verification
The assertions assume the command inputs are single-cycle pulses. They also assume memory returns read data exactly one cycle after `mem_req` with `mem_we` low. The stimulus issues every command as a one-cycle pulse between falling edges. The memory model answers every read one cycle later. Software-side writes to descriptors happen only while the engine is stopped or parked, so engine and bench never write the same word in one cycle. Descriptors are 16-byte aligned, and buffers are word-aligned.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  localparam int DW    = 32;
  localparam int LEN_W = 16;
  localparam int FLG_OWN  = 0;
  localparam int FLG_SKIP = 2;
  localparam int FLG_IRQ  = 7;
  localparam int EXT_ZLP  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_DATA, ST_ZLP, ST_WB, ST_PARK
  } tdq_state_e;
endpackage

// File: rtl/tdq_csum.sv
module tdq_csum (
  input  logic [127:0] desc,
  output logic         ok
);
  logic [7:0] acc;
  always_comb begin
    acc = 8'd1;
    for (int i = 0; i < 16; i++) begin
      if (i == 0)      acc = acc + (desc[7:0] & 8'hFE);
      else if (i != 1) acc = acc + desc[8*i +: 8];
    end
    ok = (desc[15:8] == (8'hFF - acc));
  end
endmodule

// File: rtl/tdq_out_stage.sv
module tdq_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_last,
  input  logic          ld_zlp,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          last,
  output logic          zlp
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
      zlp   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ld_data;
      last  <= ld_last;
      zlp   <= ld_zlp;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdq_engine.sv
module tdq_engine #(
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  q_start,
  input  logic [ADDR_W-1:0]     q_start_addr,
  input  logic                  q_stop,
  input  logic                  q_resume,
  input  logic                  zlp_en,
  output logic                  q_active,
  output logic [ADDR_W-1:0]     q_cur_ptr,
  output logic                  evt_done,
  output logic                  evt_cs_err,
  output logic                  evt_len_err,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-3:0]     mem_addr,
  output logic [tdq_pkg::DW-1:0] mem_wdata,
  input  logic [tdq_pkg::DW-1:0] mem_rdata,
  output logic                  pkt_valid,
  input  logic                  pkt_ready,
  output logic [tdq_pkg::DW-1:0] pkt_data,
  output logic                  pkt_last,
  output logic                  pkt_zlp
);
  import tdq_pkg::*;

  localparam int WA_W = ADDR_W - 2;
  localparam int WC_W = LEN_W - 1;
  localparam int NWD  = 4;

  tdq_state_e        state;
  logic [DW-1:0]     desc [NWD];
  logic [2:0]        iss_cnt;
  logic [1:0]        cap_cnt;
  logic              rd_pend;
  logic              rd_busy;
  logic [WA_W-1:0]   buf_wa;
  logic [WC_W-1:0]   words_left;
  logic [LEN_W-1:0]  sent_len;
  logic              need_zlp;
  logic              wb_step;
  logic              cs_ok;
  logic [LEN_W-1:0]  req_len;
  logic [LEN_W:0]    wcnt_full;
  logic [7:0]        flags;
  logic              ld_word;
  logic              ld_zlp_beat;

  assign flags     = desc[0][7:0];
  assign req_len   = desc[3][LEN_W-1:0];
  assign wcnt_full = ({1'b0, req_len} + (LEN_W+1)'(3)) >> 2;

  tdq_csum u_csum (
    .desc ({desc[3], desc[2], desc[1], desc[0]}),
    .ok   (cs_ok)
  );

  assign ld_word     = (state == ST_DATA) && rd_pend;
  assign ld_zlp_beat = (state == ST_ZLP) && !pkt_valid && !q_stop;

  tdq_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .flush   (q_stop),
    .load    (ld_word || ld_zlp_beat),
    .ld_data (ld_word ? mem_rdata : '0),
    .ld_last (ld_zlp_beat || (words_left == '0)),
    .ld_zlp  (ld_zlp_beat),
    .ready   (pkt_ready),
    .valid   (pkt_valid),
    .data    (pkt_data),
    .last    (pkt_last),
    .zlp     (pkt_zlp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      q_active    <= 1'b0;
      q_cur_ptr   <= '0;
      evt_done    <= 1'b0;
      evt_cs_err  <= 1'b0;
      evt_len_err <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      iss_cnt     <= '0;
      cap_cnt     <= '0;
      rd_pend     <= 1'b0;
      rd_busy     <= 1'b0;
      buf_wa      <= '0;
      words_left  <= '0;
      sent_len    <= '0;
      need_zlp    <= 1'b0;
      wb_step     <= 1'b0;
      for (int i = 0; i < NWD; i++) desc[i] <= '0;
    end else begin
      evt_done    <= 1'b0;
      evt_cs_err  <= 1'b0;
      evt_len_err <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      rd_pend     <= mem_req && !mem_we;
      if (q_stop) begin
        state    <= ST_IDLE;
        q_active <= 1'b0;
        rd_pend  <= 1'b0;
        rd_busy  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (q_start) begin
              q_cur_ptr <= q_start_addr;
              q_active  <= 1'b1;
              iss_cnt   <= '0;
              cap_cnt   <= '0;
              state     <= ST_FETCH;
            end
          end
          ST_FETCH: begin
            if (iss_cnt < 3'(NWD)) begin
              mem_req  <= 1'b1;
              mem_addr <= q_cur_ptr[ADDR_W-1:2] + WA_W'(iss_cnt);
              iss_cnt  <= iss_cnt + 3'd1;
            end
            if (rd_pend) begin
              desc[cap_cnt] <= mem_rdata;
              cap_cnt       <= cap_cnt + 2'd1;
              if (cap_cnt == 2'(NWD-1)) state <= ST_CHECK;
            end
          end
          ST_CHECK: begin
            need_zlp <= zlp_en && desc[0][16+EXT_ZLP];
            buf_wa   <= desc[2][ADDR_W-1:2];
            wb_step  <= 1'b0;
            if (!flags[FLG_OWN]) begin
              state <= ST_PARK;
            end else if (!cs_ok) begin
              evt_cs_err <= 1'b1;
              state      <= ST_PARK;
            end else if (flags[FLG_SKIP]) begin
              sent_len <= '0;
              state    <= ST_WB;
            end else if (req_len == '0) begin
              evt_len_err <= 1'b1;
              state       <= ST_PARK;
            end else begin
              sent_len   <= req_len;
              words_left <= wcnt_full[WC_W-1:0];
              rd_busy    <= 1'b0;
              state      <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (rd_pend) begin
              rd_busy <= 1'b0;
              if (words_left == '0) state <= need_zlp ? ST_ZLP : ST_WB;
            end else if (!rd_busy && !pkt_valid) begin
              mem_req    <= 1'b1;
              mem_addr   <= buf_wa;
              buf_wa     <= buf_wa + WA_W'(1);
              words_left <= words_left - WC_W'(1);
              rd_busy    <= 1'b1;
            end
          end
          ST_ZLP: begin
            if (!pkt_valid) state <= ST_WB;
          end
          ST_WB: begin
            mem_req <= 1'b1;
            mem_we  <= 1'b1;
            if (!wb_step) begin
              mem_addr  <= q_cur_ptr[ADDR_W-1:2] + WA_W'(3);
              mem_wdata <= {sent_len, req_len};
              wb_step   <= 1'b1;
            end else begin
              mem_addr  <= q_cur_ptr[ADDR_W-1:2];
              mem_wdata <= {desc[0][DW-1:8], flags[7:1], 1'b0};
              evt_done  <= flags[FLG_IRQ];
              q_cur_ptr <= {desc[1][ADDR_W-1:2], 2'b00};
              iss_cnt   <= '0;
              cap_cnt   <= '0;
              state     <= ST_FETCH;
            end
          end
          ST_PARK: begin
            if (q_resume) begin
              iss_cnt <= '0;
              cap_cnt <= '0;
              state   <= ST_FETCH;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdq_engine_chk.sv
module tdq_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        q_stop,
  input logic        q_active,
  input logic        evt_done,
  input logic        evt_cs_err,
  input logic        evt_len_err,
  input logic        mem_req,
  input logic        pkt_valid,
  input logic        pkt_ready,
  input logic [31:0] pkt_data,
  input logic        pkt_last,
  input logic        pkt_zlp
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !q_active |-> !pkt_valid && !mem_req); // R1
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    q_active && !q_stop |=> q_active); // R2
  AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (evt_cs_err || evt_len_err) |-> !mem_req); // R4
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_done, evt_cs_err, evt_len_err})); // R7
  AST_ZLP_SHAPE: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_zlp |-> pkt_last && pkt_data == 32'd0); // R8
  AST_STOP_DROP: assert property (@(posedge clk) disable iff (rst)
    q_stop |=> !q_active && !pkt_valid); // R12
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready && !q_stop |=>
      pkt_valid && $stable(pkt_data) && $stable(pkt_last) && $stable(pkt_zlp)); // R13
endmodule

bind tdq_engine tdq_engine_chk u_chk (.*);

// File: tb/test_tdq_engine.sv
`timescale 1ns/1ps
module test_tdq_engine;
  localparam int AW = 12;
  localparam logic [AW-1:0] D0 = 12'h100, D1 = 12'h110, D2 = 12'h120, D3 = 12'h130;
  localparam int BUFW = 12'h400 >> 2;
  // [23:19] expected words, [18] zlp_en, [17] ext zlp, [16] irq flag, [15:0] length
  localparam logic [23:0] VECS [6] = '{
    {5'd1, 1'b0, 1'b0, 1'b1, 16'd4},
    {5'd2, 1'b0, 1'b0, 1'b1, 16'd5},
    {5'd4, 1'b0, 1'b0, 1'b0, 16'd16},
    {5'd2, 1'b1, 1'b1, 1'b1, 16'd7},
    {5'd1, 1'b0, 1'b1, 1'b0, 16'd3},
    {5'd1, 1'b1, 1'b0, 1'b1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q_start = 1'b0, q_stop = 1'b0, q_resume = 1'b0, zlp_en = 1'b0;
  logic [AW-1:0] q_start_addr = '0;
  logic q_active, evt_done, evt_cs_err, evt_len_err;
  logic [AW-1:0] q_cur_ptr;
  logic mem_req, mem_we;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic pkt_valid, pkt_last, pkt_zlp;
  logic pkt_ready = 1'b1;
  logic [31:0] pkt_data;

  logic [31:0] mem [1024];
  logic tb_we = 1'b0;
  logic [9:0] tb_addr = '0;
  logic [31:0] tb_wdata = '0;
  int rdy_mode = 0;

  int n_cmp = 0, n_bad = 0;
  int beats = 0, dones = 0, cserrs = 0, lenerrs = 0;
  logic [31:0] b_data [512];
  logic b_last [512];
  logic b_zlp [512];

  always #2 clk = ~clk;

  tdq_engine #(.ADDR_W(AW)) i_tdq_engine (.*);

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_wdata;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (pkt_valid && pkt_ready && beats < 512) begin
        b_data[beats] <= pkt_data;
        b_last[beats] <= pkt_last;
        b_zlp[beats]  <= pkt_zlp;
        beats <= beats + 1;
      end
      if (evt_done) dones <= dones + 1;
      if (evt_cs_err) cserrs <= cserrs + 1;
      if (evt_len_err) lenerrs <= lenerrs + 1;
    end
  end

  always @(negedge clk)
    pkt_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ~pkt_ready : 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int wa, input logic [31:0] d);
    tb_addr = 10'(wa); tb_wdata = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [7:0] bsum(input logic [31:0] w);
    return w[7:0] + w[15:8] + w[23:16] + w[31:24];
  endfunction

  task automatic put_desc(input logic [AW-1:0] a, input logic [7:0] flg, input logic [7:0] ext,
                          input logic [31:0] nxt, input logic [31:0] bufa, input logic [15:0] len,
                          input bit bad);
    logic [7:0] s, chk;
    logic [31:0] w3;
    w3 = {16'h0, len};
    s = (flg & 8'hFE) + ext + bsum(nxt) + bsum(bufa) + bsum(w3) + 8'd1;
    chk = 8'hFF - s;
    if (bad) chk = chk ^ 8'h01;
    wr(a >> 2, {8'h00, ext, chk, flg});
    wr((a >> 2) + 1, nxt);
    wr((a >> 2) + 2, bufa);
    wr((a >> 2) + 3, w3);
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    q_start_addr = a; q_start = 1'b1;
    @(negedge clk);
    q_start = 1'b0;
  endtask

  task automatic pulse_stop();
    q_stop = 1'b1;
    @(negedge clk);
    q_stop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_resume();
    q_resume = 1'b1;
    @(negedge clk);
    q_resume = 1'b0;
  endtask

  task automatic wait_ptr(input logic [AW-1:0] p);
    for (int k = 0; k < 400 && q_cur_ptr !== p; k++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int b0, d0, c0, l0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 active", {31'd0, q_active}, 32'd0);
    check("R1 pkt_valid", {31'd0, pkt_valid}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 events", {29'd0, evt_done, evt_cs_err, evt_len_err}, 32'd0);

    // table walk: R5 R6 R7 R8 R3
    for (int v = 0; v < 6; v++) begin
      logic [15:0] len;
      int nw, zb, ir;
      len = VECS[v][15:0];
      ir  = int'(VECS[v][16]);
      zb  = int'(VECS[v][17] && VECS[v][18]);
      nw  = int'(VECS[v][23:19]);
      pulse_stop();
      put_desc(D0, {ir[0], 6'd0, 1'b1}, {2'b0, VECS[v][17], 5'b0}, 32'(D1), 32'h400, len, 1'b0);
      put_desc(D1, 8'h00, 8'h00, 32'h0, 32'h0, 16'd0, 1'b0);
      for (int i = 0; i < nw; i++) wr(BUFW + i, {8'(v), 8'hA5, 16'(i)});
      zlp_en = VECS[v][18];
      b0 = beats; d0 = dones;
      pulse_start(D0);
      wait_ptr(D1);
      check($sformatf("R5 R8 beat count v%0d", v), 32'(beats - b0), 32'(nw + zb));
      for (int i = 0; i < nw; i++) begin
        check($sformatf("R5 data v%0d w%0d", v, i), b_data[b0 + i], {8'(v), 8'hA5, 16'(i)});
        check($sformatf("R5 last v%0d w%0d", v, i), {31'd0, b_last[b0 + i]}, 32'(i == nw - 1));
      end
      if (zb != 0)
        check($sformatf("R8 zlp beat v%0d", v), {30'd0, b_zlp[b0 + nw], b_last[b0 + nw]}, 32'd3);
      check($sformatf("R7 done v%0d", v), 32'(dones - d0), 32'(ir));
      check($sformatf("R6 sent len v%0d", v), {16'd0, mem[(D0 >> 2) + 3][31:16]}, {16'd0, len});
      check($sformatf("R6 own cleared v%0d", v), {31'd0, mem[D0 >> 2][0]}, 32'd0);
      check($sformatf("R3 parked v%0d", v), {19'd0, q_active, q_cur_ptr}, {19'd0, 1'b1, D1});
    end

    // R2: start while active is ignored
    pulse_start(D3);
    repeat (6) @(negedge clk);
    check("R2 start ignored", {19'd0, q_active, q_cur_ptr}, {19'd0, 1'b1, D1});

    // R11: re-arm parked descriptor and resume
    put_desc(D1, 8'h81, 8'h00, 32'(D2), 32'h500, 16'd8, 1'b0);
    put_desc(D2, 8'h00, 8'h00, 32'h0, 32'h0, 16'd0, 1'b0);
    wr(12'h500 >> 2, 32'h1111_0000);
    wr((12'h500 >> 2) + 1, 32'h1111_0001);
    b0 = beats; d0 = dones; zlp_en = 1'b0;
    pulse_resume();
    wait_ptr(D2);
    check("R11 resume beats", 32'(beats - b0), 32'd2);
    check("R11 resume data", b_data[b0 + 1], 32'h1111_0001);
    check("R11 resume done", 32'(dones - d0), 32'd1);

    // R4: checksum mismatch
    pulse_stop();
    put_desc(D0, 8'h81, 8'h00, 32'(D1), 32'h400, 16'd4, 1'b1);
    b0 = beats; c0 = cserrs;
    pulse_start(D0);
    repeat (20) @(negedge clk);
    check("R4 cs event", 32'(cserrs - c0), 32'd1);
    check("R4 no beats", 32'(beats - b0), 32'd0);
    check("R4 parked", {19'd0, q_active, q_cur_ptr}, {19'd0, 1'b1, D0});

    // R10: zero length halts, then skip flag and resume (R9 R11)
    pulse_stop();
    put_desc(D0, 8'h81, 8'h00, 32'(D1), 32'h400, 16'd0, 1'b0);
    put_desc(D1, 8'h00, 8'h00, 32'h0, 32'h0, 16'd0, 1'b0);
    b0 = beats; l0 = lenerrs; d0 = dones;
    pulse_start(D0);
    repeat (20) @(negedge clk);
    check("R10 len event", 32'(lenerrs - l0), 32'd1);
    check("R10 no beats", 32'(beats - b0), 32'd0);
    check("R10 parked", {19'd0, q_active, q_cur_ptr}, {19'd0, 1'b1, D0});
    put_desc(D0, 8'h85, 8'h00, 32'(D1), 32'h400, 16'd0, 1'b0);
    pulse_resume();
    wait_ptr(D1);
    check("R9 skip after len err beats", 32'(beats - b0), 32'd0);
    check("R9 skip done", 32'(dones - d0), 32'd1);

    // R9: skip with nonzero length
    pulse_stop();
    put_desc(D0, 8'h05, 8'h20, 32'(D1), 32'h400, 16'd8, 1'b0);
    b0 = beats; d0 = dones; zlp_en = 1'b1;
    pulse_start(D0);
    wait_ptr(D1);
    check("R9 skip beats", 32'(beats - b0), 32'd0);
    check("R9 skip sent len", {16'd0, mem[(D0 >> 2) + 3][31:16]}, 32'd0);
    check("R9 skip own cleared", {31'd0, mem[D0 >> 2][0]}, 32'd0);
    check("R9 skip no done", 32'(dones - d0), 32'd0);
    zlp_en = 1'b0;

    // R13: backpressure keeps order
    pulse_stop();
    put_desc(D0, 8'h81, 8'h00, 32'(D1), 32'h400, 16'd12, 1'b0);
    for (int i = 0; i < 3; i++) wr(BUFW + i, 32'hBEEF_0000 + 32'(i));
    b0 = beats; rdy_mode = 1;
    pulse_start(D0);
    wait_ptr(D1);
    rdy_mode = 0;
    check("R13 beats", 32'(beats - b0), 32'd3);
    for (int i = 0; i < 3; i++)
      check($sformatf("R13 data w%0d", i), b_data[b0 + i], 32'hBEEF_0000 + 32'(i));

    // R3: unowned first descriptor
    pulse_stop();
    put_desc(D3, 8'h80, 8'h00, 32'(D0), 32'h400, 16'd4, 1'b0);
    b0 = beats;
    pulse_start(D3);
    repeat (20) @(negedge clk);
    check("R3 no beats", 32'(beats - b0), 32'd0);
    check("R3 park ptr", {19'd0, q_active, q_cur_ptr}, {19'd0, 1'b1, D3});

    // R12: stop mid-transfer
    pulse_stop();
    put_desc(D0, 8'h81, 8'h00, 32'(D1), 32'h400, 16'd64, 1'b0);
    b0 = beats; rdy_mode = 2;
    pulse_start(D0);
    repeat (30) @(negedge clk);
    q_stop = 1'b1;
    @(negedge clk);
    q_stop = 1'b0;
    check("R12 inactive", {31'd0, q_active}, 32'd0);
    rdy_mode = 0;
    repeat (20) @(negedge clk);
    check("R12 no beats", 32'(beats - b0), 32'd0);
    check("R12 no writeback", {31'd0, mem[D0 >> 2][0]}, 32'd1);
    check("R12 quiet", {30'd0, pkt_valid, mem_req}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule